// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block merges eight peripheral request lines into one active-low interrupt request for a processor. Every request line is synchronised and captured on its rising edge. At most one request per line is kept pending. Among the unmasked pending lines, the one with the lowest index wins. When the processor pulses its acknowledge input, the block puts an 8-bit vector on its vector output in that same cycle and marks the winning line as in service. The vector is a programmable base plus the line index. While a line is in service, no further request is presented. The interrupt output stays asserted until software issues an end-of-interrupt command.

Software reaches the block through a two-register port. A select input picks either the command register or the data register. An initialise command starts a short programming sequence on the data register: first the vector base, then (unless single mode was chosen) a cascade word. After that sequence, data writes set the 8-bit mask and data reads return it.

Two instances can be chained. The second instance's interrupt output, inverted, feeds one master input. In the master, a line flagged in the cascade word is treated as a level. When that line is acknowledged, the master publishes the line index on its cascade outputs instead of driving the vector. A slave drives its vector only when those cascade inputs carry its programmed identity. Its own end-of-interrupt and the master's are separate commands.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset int_n is 1, vec_drive and cas_en_o are 0, the mask reads back 8'hFF on the data register (bus_sel=1), the vector base is 0 and nothing is pending or in service.
- R2: In a cycle where inta is 1 and vec_drive is 1, vector equals the vector base plus the granted line index (mod 256), and from the next cycle that line is in service.
- R3: When several unmasked lines are pending, the lowest-numbered line is granted first.
- R4: int_n is 0 whenever a line is in service or an unmasked request is pending. After an acknowledge it remains 0 until the end-of-interrupt command: a command-register write (bus_sel=0) of 8'h20.
- R5: The end-of-interrupt command clears the in-service line. From the next cycle int_n returns to 1, unless an unmasked request is still pending, in which case int_n stays 0 with no gap.
- R6: Outside the programming sequence, a data-register write (bus_sel=1) loads the mask, and bus_rdata shows the mask while bus_sel=1. With bus_sel=0, bus_rdata is 0.
- R7: Mask bit n set to 1 blocks line n. A rising edge on a masked line is discarded, and clearing the mask bit afterwards does not raise int_n.
- R8: Each line holds at most one pending request. Several rising edges on one line while another line is in service yield exactly one grant for that line.
- R9: A request is captured only on a rising edge of the synchronised line, so a line held high gives one request. int_n falls in the cycle that follows the third rising clock edge after the line rises (two synchroniser stages plus one capture stage).
- R10: An acknowledge while a line is in service, or while no unmasked request is pending, gives vec_drive=0 and cas_en_o=0, and changes no state.
- R11: A command write with bit 4 set and bit 1 clear, and bit 3 clear, selects master role. In master role, a line whose bit is set in the cascade word is level-sensitive. Its grant gives cas_en_o=1, cas_id_o=line index and vec_drive=0. Its in-service state holds int_n at 0, even after the line falls, until the master's own end-of-interrupt.
- R12: A command write with bit 4 and bit 3 set and bit 1 clear selects slave role, and the low three bits of the cascade word give the identity. A slave grants only when inta=1, cas_en_i=1 and cas_id_i equals its identity. It then drives vec_drive=1 with its own vector.
- R13: A command write with bit 4 set (initialise) clears all pending and in-service state and sets the mask to 8'hFF. It then takes the base from the next data write, and then the cascade word, unless bit 1 (single mode) was set. Command values other than initialise and 8'h20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Peripheral request lines, rising-edge captured |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Mask when bus_sel=1, else 0 |
| inta | input | 1 | One-cycle interrupt acknowledge |
| cas_en_i | input | 1 | Slave role: master is addressing a slave |
| cas_id_i | input | 3 | Slave role: identity being addressed |
| int_n | output | 1 | Active-low interrupt request to the processor |
| vec_drive | output | 1 | This instance owns the vector in the acknowledge cycle |
| vector | output | 8 | Vector number, valid while vec_drive is 1 |
| cas_en_o | output | 1 | Master role: acknowledge forwarded to a slave |
| cas_id_o | output | 3 | Master role: index of the forwarded line |

## Verification
The bench builds the block with its defaults: eight lines, an 8-bit data path and two synchroniser stages. This makes the full priority order from line 0 to line 7 visible, and it puts vector bases such as 0x20 and 0x28 and line indices up to 7 within reach. Because the capture latency is fixed at three edges, a behavioural model can predict int_n, the vector and the cascade outputs exactly on every cycle. The same dut is reprogrammed into single, master and slave roles, so cascade forwarding, identity matching and the level treatment of a cascade line are all exercised without a second instance.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      ROLE_SINGLE = 2'd0,
      ROLE_MASTER = 2'd1,
      ROLE_SLAVE  = 2'd2
   } role_e;

   typedef enum logic [1:0] {
      CFG_IDLE = 2'd0,
      CFG_BASE = 2'd1,
      CFG_CASC = 2'd2
   } cfg_e;

   localparam logic [7:0] CMD_EOI    = 8'h20;
   localparam int         INIT_BIT   = 4;
   localparam int         SINGLE_BIT = 1;
   localparam int         SLAVE_BIT  = 3;
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
   parameter int N_LINES = 8,
   parameter int STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lines,
   output logic [N_LINES-1:0] level,
   output logic [N_LINES-1:0] rise
);
   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-1:0], lines[g]};
      end
      assign level[g] = sh[STAGES-1];
      assign rise[g]  = sh[STAGES-1] & ~sh[STAGES];
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N_LINES = 8,
   localparam int IDX_W  = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
   import irqc_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output role_e              role,
   output logic [DATA_W-1:0]  base,
   output logic [DATA_W-1:0]  casc,
   output logic [N_LINES-1:0] mask,
   output logic               init_cmd,
   output logic               eoi_cmd
);
   cfg_e state;

   assign init_cmd  = bus_wr && !bus_sel && bus_wdata[INIT_BIT];
   assign eoi_cmd   = bus_wr && !bus_sel && (bus_wdata == DATA_W'(CMD_EOI));
   assign bus_rdata = bus_sel ? DATA_W'(mask) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CFG_IDLE;
         role  <= ROLE_SINGLE;
         base  <= '0;
         casc  <= '0;
         mask  <= '1;
      end else if (init_cmd) begin
         mask  <= '1;
         casc  <= '0;
         state <= CFG_BASE;
         if (bus_wdata[SINGLE_BIT])     role <= ROLE_SINGLE;
         else if (bus_wdata[SLAVE_BIT]) role <= ROLE_SLAVE;
         else                           role <= ROLE_MASTER;
      end else if (bus_wr && bus_sel) begin
         unique case (state)
            CFG_BASE: begin
               base  <= bus_wdata;
               state <= (role == ROLE_SINGLE) ? CFG_IDLE : CFG_CASC;
            end
            CFG_CASC: begin
               casc  <= bus_wdata;
               state <= CFG_IDLE;
            end
            default: mask <= bus_wdata[N_LINES-1:0];
         endcase
      end
   end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
   import irqc_pkg::*;
#(
   parameter int N_LINES     = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               inta,
   input  logic               cas_en_i,
   input  logic [IDX_W-1:0]   cas_id_i,
   output logic               int_n,
   output logic               vec_drive,
   output logic [DATA_W-1:0]  vector,
   output logic               cas_en_o,
   output logic [IDX_W-1:0]   cas_id_o
);
   if (N_LINES < 2 || N_LINES > DATA_W) begin : g_bad_lines
      $error("irq_ctrl8: N_LINES must lie in 2..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_ctrl8: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("irq_ctrl8: DATA_W must be at least 8 to hold commands");
   end

   role_e              role;
   logic [DATA_W-1:0]  base, casc;
   logic [N_LINES-1:0] mask, level, rise, elig;
   logic [N_LINES-1:0] pend_q, isr_q, grant_vec;
   logic               init_cmd, eoi_cmd, any, in_svc, addressed, grant, to_slave;
   logic [IDX_W-1:0]   idx;

   irqc_edge_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lines(irq_in), .level(level), .rise(rise));

   irqc_cfg #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .role(role), .base(base),
      .casc(casc), .mask(mask), .init_cmd(init_cmd), .eoi_cmd(eoi_cmd));

   for (genvar g = 0; g < N_LINES; g++) begin : g_elig
      assign elig[g] = ((role == ROLE_MASTER && casc[g]) ? level[g] : pend_q[g])
                       & ~mask[g];
   end

   irqc_prio #(.N_LINES(N_LINES)) u_prio (.req(elig), .any(any), .idx(idx));

   assign in_svc    = |isr_q;
   assign addressed = (role != ROLE_SLAVE) ||
                      (cas_en_i && cas_id_i == casc[IDX_W-1:0]);
   assign grant     = inta && !in_svc && any && addressed;
   assign to_slave  = (role == ROLE_MASTER) && casc[idx];
   assign grant_vec = grant ? (N_LINES'(1) << idx) : '0;

   assign int_n     = ~(in_svc | any);
   assign vec_drive = grant && !to_slave;
   assign cas_en_o  = grant && to_slave;
   assign cas_id_o  = cas_en_o ? idx : '0;
   assign vector    = base + DATA_W'(idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         isr_q  <= '0;
      end else if (init_cmd) begin
         pend_q <= '0;
         isr_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~grant_vec) | (rise & ~mask);
         if (grant)        isr_q <= grant_vec;
         else if (eoi_cmd) isr_q <= '0;
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int N_LINES = 8,
   parameter int DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               inta,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               int_n,
   input logic               vec_drive,
   input logic               cas_en_o,
   input logic [N_LINES-1:0] isr
);
   logic eoi_w, init_w;
   assign eoi_w  = bus_wr && !bus_sel && (bus_wdata == DATA_W'(8'h20));
   assign init_w = bus_wr && !bus_sel && bus_wdata[4];

   AST_ISR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr)); // R10
   AST_HOLD_TO_EOI: assert property (@(posedge clk) disable iff (!rst_n)
      ((|isr) && !eoi_w && !init_w) |=> !int_n); // R4
   AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && (vec_drive || cas_en_o) && !bus_wr) |=> ($countones(isr) == 1)); // R2
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_drive || cas_en_o) |-> (inta && !int_n)); // R12
   AST_CAS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_drive && cas_en_o)); // R11
   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_w && !inta) |=> (isr == '0)); // R5
   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_w |=> (isr == '0)); // R13
endmodule

bind irq_ctrl8 irqc_checker #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .inta(inta), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .int_n(int_n), .vec_drive(vec_drive),
   .cas_en_o(cas_en_o), .isr(isr_q));

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;
   logic       clk = 0, rst_n = 0;
   logic [7:0] irq_in = 0, bus_wdata = 0, bus_rdata, vector;
   logic       bus_sel = 0, bus_wr = 0, inta = 0, cas_en_i = 0;
   logic [2:0] cas_id_i = 0, cas_id_o;
   logic       int_n, vec_drive, cas_en_o;
   int         errors = 0, checks = 0;
   bit         done = 0;

   always #5 clk = ~clk;

   irq_ctrl8 dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inta(inta),
      .cas_en_i(cas_en_i), .cas_id_i(cas_id_i), .int_n(int_n), .vec_drive(vec_drive),
      .vector(vector), .cas_en_o(cas_en_o), .cas_id_o(cas_id_o));

   // Behavioural reference: role 0 single, 1 master, 2 slave; cfg 0 idle, 1 base, 2 cascade word
   logic [7:0] m_s1, m_s2, m_s3, m_pend, m_isr, m_mask, m_base, m_casc, m_elig;
   int         m_role, m_cfg, m_idx;
   bit         m_grant, e_vd, e_ce, e_intn;
   logic [7:0] e_vec, e_rd;
   logic [2:0] e_cid;

   task automatic model_eval();
      bit addr, p;
      m_elig = 0;
      for (int i = 0; i < 8; i++) begin
         p = (m_role == 1 && m_casc[i]) ? m_s2[i] : m_pend[i];
         m_elig[i] = p & ~m_mask[i];
      end
      m_idx = -1;
      for (int i = 7; i >= 0; i--) if (m_elig[i]) m_idx = i;
      addr    = (m_role != 2) || (cas_en_i && cas_id_i == m_casc[2:0]);
      m_grant = inta && m_isr == 0 && m_idx >= 0 && addr;
      e_ce    = m_grant && m_role == 1 && m_casc[m_idx];
      e_vd    = m_grant && !e_ce;
      e_cid   = e_ce ? 3'(m_idx) : 3'd0;
      e_vec   = m_base + 8'(m_idx);
      e_intn  = !(m_isr != 0 || m_elig != 0);
      e_rd    = bus_sel ? m_mask : 8'h00;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pend = 0; m_isr = 0; m_mask = 8'hFF;
         m_base = 0; m_casc = 0; m_role = 0; m_cfg = 0;
      end else begin
         logic [7:0] newp;
         model_eval();
         newp = (m_s2 & ~m_s3) & ~m_mask;
         if (m_grant) m_pend[m_idx] = 1'b0;
         m_pend = m_pend | newp;
         if (bus_wr && !bus_sel && bus_wdata == 8'h20) m_isr = 0;
         if (m_grant) m_isr = 8'(1) << m_idx;
         if (bus_wr && bus_sel) begin
            if (m_cfg == 1) begin m_base = bus_wdata; m_cfg = (m_role == 0) ? 0 : 2; end
            else if (m_cfg == 2) begin m_casc = bus_wdata; m_cfg = 0; end
            else m_mask = bus_wdata;
         end
         if (bus_wr && !bus_sel && bus_wdata[4]) begin
            m_pend = 0; m_isr = 0; m_mask = 8'hFF; m_casc = 0; m_cfg = 1;
            m_role = bus_wdata[1] ? 0 : (bus_wdata[3] ? 2 : 1);
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
      end
   end

   task automatic cmp(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         model_eval();
         cmp("R4 int_n vs model", int_n, e_intn);
         cmp("R12 vec_drive vs model", vec_drive, e_vd);
         cmp("R11 cas_en_o vs model", cas_en_o, e_ce);
         cmp("R11 cas_id_o vs model", cas_id_o, e_cid);
         cmp("R6 bus_rdata vs model", bus_rdata, e_rd);
         if (e_vd) cmp("R2 vector vs model", vector, e_vec);
      end
   end

   // Directed helpers: all start and end just after a falling edge
   task automatic wr(input logic sel, input logic [7:0] d);
      bus_sel = sel; bus_wr = 1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   logic       a_vd, a_ce;
   logic [7:0] a_vec;
   logic [2:0] a_cid;
   task automatic ack();
      inta = 1;
      #3; a_vd = vec_drive; a_ce = cas_en_o; a_vec = vector; a_cid = cas_id_o;
      @(negedge clk);
      inta = 0;
   endtask

   task automatic now(input string what, input int act, input int exp);
      #3; cmp(what, act, exp); @(negedge clk);
   endtask

   initial begin
      cycles(3);
      rst_n = 1;
      bus_sel = 1;
      #3;
      cmp("R1 reset int_n", int_n, 1);
      cmp("R1 reset mask readback", bus_rdata, 8'hFF);
      cmp("R1 reset vec_drive", vec_drive, 0);
      @(negedge clk);

      // single role, base 0x20, mask open
      wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h00);
      bus_sel = 1;
      now("R6 mask readback after write", bus_rdata, 8'h00);

      irq_in[3] = 1;
      cycles(2);
      now("R9 int_n still high two edges after rise", int_n, 1);
      now("R9 int_n low three edges after rise", int_n, 0);
      ack();
      cmp("R2 vec_drive on ack", a_vd, 1);
      cmp("R2 vector line 3", a_vec, 8'h23);
      irq_in[1] = 1; irq_in[5] = 1;
      now("R4 int_n held after ack", int_n, 0);
      cycles(3);
      irq_in[1] = 0; cycles(3);
      irq_in[1] = 1; cycles(4);
      ack();
      cmp("R10 ack while in service ignored", a_vd, 0);
      wr(0, 8'h20);
      now("R5 int_n stays low after EOI with pending", int_n, 0);
      ack();
      cmp("R3 lowest line granted", a_vec, 8'h21);
      wr(0, 8'h20);
      ack();
      cmp("R8 next grant is line 5", a_vec, 8'h25);
      wr(0, 8'h20);
      now("R8 no second line-1 request, R9 held line 3 silent", int_n, 1);
      irq_in = 0;
      cycles(4);

      // mask behaviour
      wr(1, 8'h01);
      bus_sel = 1;
      now("R6 mask readback 0x01", bus_rdata, 8'h01);
      irq_in[0] = 1; cycles(5);
      now("R7 masked edge blocked", int_n, 1);
      wr(1, 8'h00); cycles(2);
      now("R7 unmask does not revive dropped edge", int_n, 1);
      irq_in = 0;
      bus_sel = 0;
      now("R6 command read returns zero", bus_rdata, 0);
      cycles(3);

      // empty acknowledge, ignored command
      ack();
      cmp("R10 ack with nothing pending", a_vd, 0);
      irq_in[4] = 1; cycles(4);
      ack();
      cmp("R2 vector line 4", a_vec, 8'h24);
      irq_in[0] = 1; cycles(4);
      wr(0, 8'h05);
      now("R13 unknown command keeps service", int_n, 0);
      ack();
      cmp("R13 unknown command did not end service", a_vd, 0);
      wr(0, 8'h20);
      ack();
      cmp("R3 line 0 after EOI", a_vec, 8'h20);
      wr(0, 8'h20);
      now("R5 int_n released after final EOI", int_n, 1);
      irq_in = 0; cycles(4);

      // reinitialise clears pending and restores mask
      irq_in[6] = 1; cycles(4);
      now("R4 int_n low on pending line 6", int_n, 0);
      wr(0, 8'h13);
      bus_sel = 1;
      #3;
      cmp("R13 init drops pending", int_n, 1);
      cmp("R13 init sets mask", bus_rdata, 8'hFF);
      @(negedge clk);
      wr(1, 8'h20); wr(1, 8'h00); cycles(3);
      now("R9 held line gives no new request", int_n, 1);
      irq_in = 0; cycles(4);

      // master role, cascade on line 2
      wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h00);
      irq_in[2] = 1; cycles(4);
      now("R11 cascade level request", int_n, 0);
      ack();
      cmp("R11 forwarded cas_en_o", a_ce, 1);
      cmp("R11 forwarded cas_id_o", a_cid, 2);
      cmp("R11 master does not drive vector", a_vd, 0);
      wr(0, 8'h20);
      now("R11 level line re-requests after EOI", int_n, 0);
      ack();
      cmp("R11 second forward", a_ce, 1);
      irq_in[2] = 0; cycles(4);
      now("R11 in service holds int_n after line falls", int_n, 0);
      wr(0, 8'h20);
      now("R11 released by master EOI", int_n, 1);
      irq_in[5] = 1; cycles(4);
      ack();
      cmp("R2 master direct line vector", a_vec, 8'h25);
      cmp("R11 direct line not forwarded", a_ce, 0);
      wr(0, 8'h20);
      irq_in = 0; cycles(4);

      // slave role, identity 2, base 0x28
      wr(0, 8'h19); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h00);
      irq_in[6] = 1; cycles(4);
      cas_en_i = 1; cas_id_i = 3;
      ack();
      cmp("R12 wrong identity ignored", a_vd, 0);
      now("R12 request still pending", int_n, 0);
      cas_id_i = 2;
      ack();
      cmp("R12 matching identity drives", a_vd, 1);
      cmp("R12 slave vector", a_vec, 8'h2E);
      cas_en_i = 0;
      wr(0, 8'h20);
      now("R5 slave released by EOI", int_n, 1);
      irq_in = 0; cycles(3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule